// File: doc/BRIEF.md
# UART Interrupt and Status Controller

This block is the flag-keeping and interrupt section of a UART that sits on a processor bus. The receiver and transmitter cores report their events to it as single-cycle strobes: a character was loaded into the receive holding register, the transmit holding register became free, the shift register finished. It also watches two slow modem-style inputs, a peripheral status line and a clear-to-send line. From these it keeps the status flags and drives an active-low interrupt line. It also drives a framing-error output and a combined parity/overrun output.

The processor clears each interrupt cause with a register access. An access counts only while the three chip selects have the right levels. It takes effect on an edge of a timing pulse, seen as a level that the block samples on its clock. Each cause has its own clearing access and its own edge of the pulse, leading or trailing. Two control bits, written through the same bus, gate the interrupt. One is a master enable. The other separately admits the holding-register-empty cause. Serial shifting, baud timing and parity computation stay in the cores and reach this block only as strobes.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is asserted, and right after it, `intN` is high. The control bits and all pending causes are clear, the framing and parity/overrun outputs are low, and `statusOut` reads 8'hC0 (only the two transmitter-empty bits set).
- R2: An access counts only when `chipSel1`=1, `chipSel2`=0 and `chipSel3`=1. `rdWr`=1 is a read and 0 is a write. With `regSel`=1 a write targets the control register and a read targets the status register. With `regSel`=0 the access targets the data registers. Any access with other chip-select levels changes nothing.
- R3: `rxLoad` sets data-available (`statusOut` bit 0). A data read on a leading edge of `timePulse` (0 sampled, then 1) clears it.
- R4: `txHoldFree` sets the holding-empty status (bit 7) and the holding-empty cause. A data write on a leading edge clears the status bit. The cause is cleared by a status read or a data write on a leading edge. The cause drives the interrupt only while control bit `wrData[1]` (transmit request) is set.
- R5: A transmitter-done cause is raised one cycle after holding-empty and shift-empty (bit 6, set by `txShiftDone`, cleared by a data write) become true together. A status read or data write on a leading edge clears it.
- R6: A falling edge on `periphIn` sets the peripheral cause (bit 4). Only a status read on a trailing edge of `timePulse` (1 sampled, then 0) clears it. A leading edge leaves it set.
- R7: A rising edge on `ctsIn` sets the clear-to-send cause (bit 5) only while holding-empty and shift-empty are both set. A status read on a leading edge clears it.
- R8: `intN` is low exactly when control bit `wrData[0]` (interrupt enable) is set and at least one admitted cause is pending. Clearing the enable raises `intN` and keeps the flags.
- R9: `frameErr` (also `statusOut` bit 3) takes the inverse of `rxStopBit` on each `rxLoad` and holds its value otherwise.
- R10: `rxLoad` with `rxParErr` sets parity error (bit 2). `rxLoad` while data-available is still set sets overrun (bit 1). A status read on a leading edge clears both. `parOvrErr` is high while either is set.
- R11: When a set event and a clearing access hit the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel1 | input | 1 | Chip select, active high |
| chipSel2 | input | 1 | Chip select, active low |
| chipSel3 | input | 1 | Chip select, active high |
| rdWr | input | 1 | 1 = read, 0 = write |
| regSel | input | 1 | 1 = control/status, 0 = data registers |
| timePulse | input | 1 | Bus timing pulse, sampled as a level |
| wrData | input | CTRL_W | Control register write value |
| rxLoad | input | 1 | Strobe: character moved to receive holding register |
| rxStopBit | input | 1 | Stop-position bit of that character |
| rxParErr | input | 1 | Parity check failed for that character |
| txHoldFree | input | 1 | Strobe: transmit holding register emptied |
| txShiftDone | input | 1 | Strobe: transmit shift register emptied |
| periphIn | input | 1 | Peripheral status input |
| ctsIn | input | 1 | Clear-to-send input |
| intN | output | 1 | Interrupt request, active low |
| statusOut | output | 8 | Status register read value |
| frameErr | output | 1 | Framing error |
| parOvrErr | output | 1 | Parity or overrun error |

## Verification
The bench builds the block with its defaults: a two-bit control register with enable in bit 0 and transmit request in bit 1, and a two-stage input synchronizer. With two stages, a peripheral or clear-to-send edge reaches its flag three clocks after the pin changes. The directed tests therefore wait several clocks before sampling, and they can show that a rising clear-to-send edge during transmission is dropped. With the two-bit control register, the bench can enable the master gate and the transmit-request gate one at a time, so the holding-empty cause and the transmitter-done cause can each be seen alone.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int STAT_W = 8;

  // status register bit positions
  localparam int ST_DA   = 0;
  localparam int ST_OE   = 1;
  localparam int ST_PE   = 2;
  localparam int ST_FE   = 3;
  localparam int ST_PSI  = 4;
  localparam int ST_CTS  = 5;
  localparam int ST_TSRE = 6;
  localparam int ST_THRE = 7;

  // qualified bus accesses, one strobe per kind
  typedef struct packed {
    logic ctrlWr;
    logic dataWr;
    logic dataRd;
    logic statRdLead;
    logic statRdTrail;
  } accStrobeT;

endpackage

// File: rtl/uirq_sync.sv
module uirq_sync #(
  parameter int  LEN     = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  generate
    if (LEN == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [LEN-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= {LEN{RST_VAL}};
        else       stageQ <= {stageQ[LEN-2+((LEN==1)?1:0):0], din};
      end
      assign dout = stageQ[LEN-1];
    end
  endgenerate

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSel1,
  input  logic      chipSel2,
  input  logic      chipSel3,
  input  logic      rdWr,
  input  logic      regSel,
  input  logic      timePulse,
  output accStrobeT stb
);

  logic pulseQ;
  logic leadEdge;
  logic trailEdge;
  logic selOk;
  logic rdAcc;
  logic wrAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= timePulse;
  end

  assign leadEdge  = timePulse & ~pulseQ;
  assign trailEdge = ~timePulse & pulseQ;
  assign selOk     = chipSel1 & ~chipSel2 & chipSel3;
  assign rdAcc     = selOk & rdWr;
  assign wrAcc     = selOk & ~rdWr;

  always_comb begin
    stb             = '0;
    stb.ctrlWr      = wrAcc & regSel & leadEdge;
    stb.dataWr      = wrAcc & ~regSel & leadEdge;
    stb.dataRd      = rdAcc & ~regSel & leadEdge;
    stb.statRdLead  = rdAcc & regSel & leadEdge;
    stb.statRdTrail = rdAcc & regSel & trailEdge;
  end

endmodule

// File: rtl/uirq_dp.sv
module uirq_dp
  import uirq_pkg::*;
#(
  parameter int CTRL_W     = 2,
  parameter int INT_EN_BIT = 0,
  parameter int TX_REQ_BIT = 1,
  parameter int SYNC_LEN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobeT         stb,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              rxLoad,
  input  logic              rxStopBit,
  input  logic              rxParErr,
  input  logic              txHoldFree,
  input  logic              txShiftDone,
  input  logic              periphIn,
  input  logic              ctsIn,
  output logic              intN,
  output logic [STAT_W-1:0] statusOut,
  output logic              frameErr,
  output logic              parOvrErr
);

  logic [CTRL_W-1:0] ctrlReg;
  logic daPend, threPend, donePend, psiPend, ctsPend;
  logic oeBit, peBit, feBit;
  logic threStat, tsreStat;
  logic idleQ, psiQ, ctsQ;
  logic psiSync, ctsSync;
  logic txIdle, doneRise, psiFall, ctsRise;
  logic txClr, anyCause;

  uirq_sync #(.LEN(SYNC_LEN), .RST_VAL(1'b1)) psiSync_i (
    .clk(clk), .rstN(rstN), .din(periphIn), .dout(psiSync));
  uirq_sync #(.LEN(SYNC_LEN), .RST_VAL(1'b1)) ctsSync_i (
    .clk(clk), .rstN(rstN), .din(ctsIn), .dout(ctsSync));

  assign txIdle   = threStat & tsreStat;
  assign doneRise = txIdle & ~idleQ;
  assign psiFall  = ~psiSync & psiQ;
  assign ctsRise  = ctsSync & ~ctsQ;
  assign txClr    = stb.statRdLead | stb.dataWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      daPend   <= 1'b0;
      threPend <= 1'b0;
      donePend <= 1'b0;
      psiPend  <= 1'b0;
      ctsPend  <= 1'b0;
      oeBit    <= 1'b0;
      peBit    <= 1'b0;
      feBit    <= 1'b0;
      threStat <= 1'b1;
      tsreStat <= 1'b1;
      idleQ    <= 1'b1;
      psiQ     <= 1'b1;
      ctsQ     <= 1'b1;
    end else begin
      psiQ  <= psiSync;
      ctsQ  <= ctsSync;
      idleQ <= txIdle;
      if (stb.ctrlWr) ctrlReg <= wrData;
      if (rxLoad)     feBit   <= ~rxStopBit;
      // set terms are OR-ed last so an event beats a clear in the same cycle
      daPend   <= (daPend   & ~stb.dataRd)      | rxLoad;
      oeBit    <= (oeBit    & ~stb.statRdLead)  | (rxLoad & daPend);
      peBit    <= (peBit    & ~stb.statRdLead)  | (rxLoad & rxParErr);
      threStat <= (threStat & ~stb.dataWr)      | txHoldFree;
      tsreStat <= (tsreStat & ~stb.dataWr)      | txShiftDone;
      threPend <= (threPend & ~txClr)           | txHoldFree;
      donePend <= (donePend & ~txClr)           | doneRise;
      psiPend  <= (psiPend  & ~stb.statRdTrail) | psiFall;
      ctsPend  <= (ctsPend  & ~stb.statRdLead)  | (ctsRise & txIdle);
    end
  end

  assign anyCause = daPend | (threPend & ctrlReg[TX_REQ_BIT]) | donePend
                  | psiPend | ctsPend;
  assign intN      = ~(ctrlReg[INT_EN_BIT] & anyCause);
  assign frameErr  = feBit;
  assign parOvrErr = peBit | oeBit;

  always_comb begin
    statusOut          = '0;
    statusOut[ST_DA]   = daPend;
    statusOut[ST_OE]   = oeBit;
    statusOut[ST_PE]   = peBit;
    statusOut[ST_FE]   = feBit;
    statusOut[ST_PSI]  = psiPend;
    statusOut[ST_CTS]  = ctsPend;
    statusOut[ST_TSRE] = tsreStat;
    statusOut[ST_THRE] = threStat;
  end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
#(
  parameter int CTRL_W     = 2,
  parameter int INT_EN_BIT = 0,
  parameter int TX_REQ_BIT = 1,
  parameter int SYNC_LEN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel1,
  input  logic              chipSel2,
  input  logic              chipSel3,
  input  logic              rdWr,
  input  logic              regSel,
  input  logic              timePulse,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              rxLoad,
  input  logic              rxStopBit,
  input  logic              rxParErr,
  input  logic              txHoldFree,
  input  logic              txShiftDone,
  input  logic              periphIn,
  input  logic              ctsIn,
  output logic              intN,
  output logic [7:0]        statusOut,
  output logic              frameErr,
  output logic              parOvrErr
);

  accStrobeT accStb;

  uirq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .chipSel1(chipSel1), .chipSel2(chipSel2), .chipSel3(chipSel3),
    .rdWr(rdWr), .regSel(regSel), .timePulse(timePulse),
    .stb(accStb)
  );

  uirq_dp #(
    .CTRL_W(CTRL_W), .INT_EN_BIT(INT_EN_BIT),
    .TX_REQ_BIT(TX_REQ_BIT), .SYNC_LEN(SYNC_LEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(accStb), .wrData(wrData),
    .rxLoad(rxLoad), .rxStopBit(rxStopBit), .rxParErr(rxParErr),
    .txHoldFree(txHoldFree), .txShiftDone(txShiftDone),
    .periphIn(periphIn), .ctsIn(ctsIn),
    .intN(intN), .statusOut(statusOut),
    .frameErr(frameErr), .parOvrErr(parOvrErr)
  );

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
  import uirq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       chipSel1,
  input logic       chipSel2,
  input logic       chipSel3,
  input logic       rdWr,
  input logic       regSel,
  input logic       timePulse,
  input logic       rxLoad,
  input logic       rxStopBit,
  input logic       rxParErr,
  input logic       intN,
  input logic [7:0] statusOut,
  input logic       frameErr,
  input logic       parOvrErr
);

  logic pulseSeenQ;
  logic ctrlSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseSeenQ <= 1'b0;
      ctrlSeen   <= 1'b0;
    end else begin
      pulseSeenQ <= timePulse;
      if (chipSel1 && !chipSel2 && chipSel3 && !rdWr && regSel
          && timePulse && !pulseSeenQ)
        ctrlSeen <= 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> intN);

  p_da_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad |=> statusOut[ST_DA]);

  p_no_int_before_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlSeen |-> intN);

  p_fe_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad |=> (frameErr == !$past(rxStopBit)));

  p_fe_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rxLoad |=> $stable(frameErr));

  p_pe_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && rxParErr) |=> (parOvrErr && statusOut[ST_PE]));

  p_overrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && statusOut[ST_DA]) |=> (parOvrErr && statusOut[ST_OE]));

endmodule

bind uart_irq_status uart_irq_status_chk chk_i (.*);

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic O = 1'b0;
  localparam logic I = 1'b1;

  typedef struct packed {
    logic       tp, c1, c2, c3, rw, rs;
    logic [1:0] wd;
    logic       rl, sb, pe, hf, sd;
    logic       eInt;
    logic [7:0] eStat;
    logic       eFe, ePo;
  } stepT;

  // R2 R3 R4 R8 R9 R10 R11 walked as one sequence
  localparam stepT TABLE [23] = '{
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, I,8'hC0,O,O},
    '{I,I,O,I,O,I,2'b01, O,I,O,O,O, I,8'hC0,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, I,8'hC0,O,O},
    '{O,O,O,O,O,O,2'b00, I,I,O,O,O, O,8'hC1,O,O},
    '{O,O,O,O,O,O,2'b00, I,O,I,O,O, O,8'hCF,I,I},
    '{I,I,O,I,I,I,2'b00, O,I,O,O,O, O,8'hC9,I,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, O,8'hC9,I,O},
    '{I,I,O,I,I,O,2'b00, I,I,O,O,O, O,8'hC3,O,I},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, O,8'hC3,O,I},
    '{I,I,O,I,I,O,2'b00, O,I,O,O,O, I,8'hC2,O,I},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, I,8'hC2,O,I},
    '{I,I,I,I,I,I,2'b00, O,I,O,O,O, I,8'hC2,O,I},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, I,8'hC2,O,I},
    '{I,I,O,I,I,I,2'b00, O,I,O,O,O, I,8'hC0,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,I,O, I,8'hC0,O,O},
    '{I,I,O,I,O,I,2'b11, O,I,O,O,O, O,8'hC0,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, O,8'hC0,O,O},
    '{I,I,O,I,O,O,2'b00, O,I,O,O,O, I,8'h00,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,I,O, O,8'h80,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,I, O,8'hC0,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, O,8'hC0,O,O},
    '{I,I,O,I,I,I,2'b00, O,I,O,O,O, I,8'hC0,O,O},
    '{O,O,O,O,O,O,2'b00, O,I,O,O,O, I,8'hC0,O,O}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       chipSel1 = 1'b0, chipSel2 = 1'b0, chipSel3 = 1'b0;
  logic       rdWr = 1'b0, regSel = 1'b0, timePulse = 1'b0;
  logic [1:0] wrData = 2'b00;
  logic       rxLoad = 1'b0, rxStopBit = 1'b1, rxParErr = 1'b0;
  logic       txHoldFree = 1'b0, txShiftDone = 1'b0;
  logic       periphIn = 1'b1, ctsIn = 1'b0;
  logic       intN, frameErr, parOvrErr;
  logic [7:0] statusOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_status dut_i (
    .clk(clk), .rstN(rstN),
    .chipSel1(chipSel1), .chipSel2(chipSel2), .chipSel3(chipSel3),
    .rdWr(rdWr), .regSel(regSel), .timePulse(timePulse), .wrData(wrData),
    .rxLoad(rxLoad), .rxStopBit(rxStopBit), .rxParErr(rxParErr),
    .txHoldFree(txHoldFree), .txShiftDone(txShiftDone),
    .periphIn(periphIn), .ctsIn(ctsIn),
    .intN(intN), .statusOut(statusOut),
    .frameErr(frameErr), .parOvrErr(parOvrErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // full access: leading edge, trailing edge, then deselect
  task automatic access(input logic rw, input logic rs, input logic [1:0] wd);
    chipSel1 = 1'b1; chipSel2 = 1'b0; chipSel3 = 1'b1;
    rdWr = rw; regSel = rs; wrData = wd; timePulse = 1'b1;
    @(negedge clk);
    timePulse = 1'b0;
    @(negedge clk);
    chipSel1 = 1'b0; chipSel3 = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseEvent(input int which);
    if (which == 0) txHoldFree = 1'b1;
    else if (which == 1) txShiftDone = 1'b1;
    else rxLoad = 1'b1;
    @(negedge clk);
    txHoldFree = 1'b0; txShiftDone = 1'b0; rxLoad = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rstN = 1'b0;
    idleCycles(3);
    // R1: reset state
    check("R1 intN in reset", intN, 1);
    check("R1 status in reset", statusOut, 8'hC0);
    check("R1 errors in reset", {frameErr, parOvrErr}, 0);
    rstN = 1'b1;
    idleCycles(1);
    check("R1 intN after reset", intN, 1);

    foreach (TABLE[i]) begin
      timePulse = TABLE[i].tp; chipSel1 = TABLE[i].c1;
      chipSel2 = TABLE[i].c2;  chipSel3 = TABLE[i].c3;
      rdWr = TABLE[i].rw; regSel = TABLE[i].rs; wrData = TABLE[i].wd;
      rxLoad = TABLE[i].rl; rxStopBit = TABLE[i].sb; rxParErr = TABLE[i].pe;
      txHoldFree = TABLE[i].hf; txShiftDone = TABLE[i].sd;
      @(negedge clk);
      check($sformatf("R3/R8 table step %0d intN", i), intN, TABLE[i].eInt);
      check($sformatf("R10/R11 table step %0d status", i), statusOut, TABLE[i].eStat);
      check($sformatf("R9 table step %0d frameErr", i), frameErr, TABLE[i].eFe);
      check($sformatf("R10 table step %0d parOvrErr", i), parOvrErr, TABLE[i].ePo);
    end
    chipSel1 = 1'b0; chipSel2 = 1'b0; chipSel3 = 1'b0; timePulse = 1'b0;
    rxLoad = 1'b0; txHoldFree = 1'b0; txShiftDone = 1'b0;
    idleCycles(1);

    // R5: done cause alone, transmit request off
    access(1'b0, 1'b1, 2'b01);
    access(1'b0, 1'b0, 2'b00);
    check("R5 data write empties tx", statusOut, 8'h00);
    pulseEvent(0);
    idleCycles(2);
    check("R4 holding cause masked without request", intN, 1);
    pulseEvent(1);
    idleCycles(2);
    check("R5 done cause interrupts", intN, 0);
    access(1'b1, 1'b1, 2'b00);
    check("R5 status read clears done", intN, 1);

    // R7: cts rise ignored while transmitting
    access(1'b0, 1'b0, 2'b00);
    ctsIn = 1'b1;
    idleCycles(5);
    check("R7 cts rise while busy ignored", intN, 1);
    check("R7 cts bit stays clear", statusOut[5], 0);
    ctsIn = 1'b0;
    idleCycles(4);
    pulseEvent(0);
    pulseEvent(1);
    idleCycles(2);
    access(1'b1, 1'b1, 2'b00);
    check("R7 tx idle and quiet", {intN, statusOut}, {1'b1, 8'hC0});
    ctsIn = 1'b1;
    idleCycles(5);
    check("R7 cts rise while idle", {intN, statusOut}, {1'b0, 8'hE0});
    access(1'b1, 1'b1, 2'b00);
    check("R7 status read clears cts", {intN, statusOut}, {1'b1, 8'hC0});

    // R6: peripheral falling edge, cleared only on trailing edge
    periphIn = 1'b0;
    idleCycles(5);
    check("R6 peripheral fall sets cause", {intN, statusOut}, {1'b0, 8'hD0});
    chipSel1 = 1'b1; chipSel3 = 1'b1; rdWr = 1'b1; regSel = 1'b1; timePulse = 1'b1;
    @(negedge clk);
    check("R6 leading edge leaves cause", {intN, statusOut}, {1'b0, 8'hD0});
    timePulse = 1'b0;
    @(negedge clk);
    check("R6 trailing edge clears cause", {intN, statusOut}, {1'b1, 8'hC0});
    chipSel1 = 1'b0; chipSel3 = 1'b0;
    periphIn = 1'b1;
    idleCycles(5);
    check("R6 peripheral rise ignored", intN, 1);

    // R8 and R2: enable gate, bad chip select on control write
    pulseEvent(2);
    check("R8 data available interrupts", intN, 0);
    chipSel1 = 1'b1; chipSel2 = 1'b0; chipSel3 = 1'b0;
    rdWr = 1'b0; regSel = 1'b1; wrData = 2'b00; timePulse = 1'b1;
    @(negedge clk);
    timePulse = 1'b0;
    @(negedge clk);
    chipSel1 = 1'b0;
    check("R2 deselected control write ignored", intN, 0);
    access(1'b0, 1'b1, 2'b00);
    check("R8 enable off raises intN", {intN, statusOut}, {1'b1, 8'hC1});
    access(1'b0, 1'b1, 2'b01);
    check("R8 enable on lowers intN", intN, 0);

    // R1: reset mid-run
    rstN = 1'b0;
    idleCycles(2);
    rstN = 1'b1;
    idleCycles(1);
    check("R1 reset clears causes", {intN, statusOut, frameErr, parOvrErr},
          {1'b1, 8'hC0, 1'b0, 1'b0});

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule